// File: doc/BRIEF.md
# Dual Parallel-Port Digital I/O Controller

This block drives 48 digital lines from a byte-wide register bus with a 16-byte address window. The lines are split into two identical groups. Each group has three 8-bit ports, called A, B and C, and a mode register. The mode register sets the direction of port A and port B as whole bytes. It sets the direction of each 4-bit half of port C on its own. Every port has an output latch that keeps its value when the port is switched to input, so a port that goes back to output drives its old value again.

Bit 3 of port C in each group is also watched for rising edges. A small interrupt unit records these edges and raises a level request. Software controls the unit only by accessing fixed offsets: a write to one offset arms it, a read of the same offset disarms it, and a write to a second offset clears what has been recorded. Bus accesses are single-cycle strobes. Read data is combinational from the current state. Writes and side effects take effect at the clock edge.

Top module: `dio48_ctrl`

## Requirements
- R1: Offsets 0, 1 and 2 are ports A, B and C of group 0, and offset 3 is its mode register. Offsets 4 to 7 hold the same layout for group 1. Output line n belongs to port n/8, with ports in the order A0, B0, C0, A1, B1, C1, and a port write sets that port's latch on the lines one cycle later.
- R2: After reset every line is driven (`pins_oe` all ones), `pins_out` is all zeros, both mode registers read 0x80, and the interrupt request is low.
- R3: A mode write with bit 7 = 1 sets the directions. Bit 4 = 1 makes port A an input and bit 1 = 1 makes port B an input. A 0 in these bits means output. `pins_oe` changes one cycle after the write.
- R4: In a mode write, bit 3 sets the upper nibble of port C and bit 0 sets the lower nibble, with 1 meaning input. The two nibbles are independent of each other.
- R5: A write to a mode register with bit 7 = 0 changes no direction.
- R6: A port latch keeps its value while the port is an input, and `pins_out` keeps showing it. When the port is switched back to output, that value is driven again.
- R7: A port read returns the pin value for input bits and the latch value for output bits. Pin values pass through one sampling register. A mode read returns 0x80 with the direction bits in the positions of R3 and R4. Reads of offsets 8 to 15 return 0.
- R8: When the interrupt unit is armed, a rising edge on line 19 or line 43 (sampled low, then high) raises `irq_req` two cycles after the pin change. Falling edges and other lines do not raise it.
- R9: A write of any value to offset 0xB arms the interrupt unit. A read of offset 0xB disarms it and drops any recorded edge. The unit is disarmed out of reset.
- R10: `irq_req` is a level. It stays high until a write of any value to offset 0xF clears the recorded edges, and it is low one cycle after that write.
- R11: Edges that occur while the unit is disarmed are not recorded, so arming the unit afterwards leaves `irq_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pins_in | input | 48 | Line input values |
| pins_out | output | 48 | Latched output values |
| pins_oe | output | 48 | Drive enable per line, 1 = output |
| irq_req | output | 1 | Level interrupt request |

## Verification
Writes and the arm, disarm and clear accesses take effect at the clock edge that samples the strobe. The bench drives inputs on the falling edge and checks `pins_out`, `pins_oe` and `irq_req` at the next falling edge, which is one cycle after the strobe. Read data is sampled 2 ns into the strobe cycle, and a pin change made on a falling edge can be read back from the next access onward. A rising edge on line 19 or 43 is expected on `irq_req` exactly two falling edges after the pin change, and the checks for disarm, clear and ignored edges sample at that same point.

// File: rtl/dio48_pkg.sv
package dio48_pkg;
    parameter int PORT_W        = 8;
    parameter int PORTS_PER_GRP = 3;
    parameter int NUM_GRP       = 2;
    parameter int ADDR_W        = 4;
    parameter int IRQ_BIT       = 3;
    parameter int MODE_BIT      = 7;

    localparam int GRP_LINES = PORT_W * PORTS_PER_GRP;
    localparam int NUM_LINES = GRP_LINES * NUM_GRP;
    localparam int IDX_W     = 2;
    localparam int GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int GRP_SPAN  = 1 << IDX_W;
    localparam int CTL_IDX   = GRP_SPAN - 1;
    localparam int NIB_W     = PORT_W / 2;
    localparam logic [ADDR_W-1:0] IRQ_ARM_OFS = ADDR_W'(4'hB);
    localparam logic [ADDR_W-1:0] IRQ_CLR_OFS = ADDR_W'(4'hF);

    // Direction of one group, 1 = input
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic chi_in;
        logic clo_in;
    } dir_t;

    typedef struct packed {
        logic             hit_grp;
        logic [GRP_W-1:0] grp;
        logic [IDX_W-1:0] idx;
        logic             irq_arm;
        logic             irq_clr;
    } sel_t;

    function automatic dir_t mode_decode(input logic [PORT_W-1:0] w);
        dir_t d;
        d.a_in   = w[4];
        d.b_in   = w[1];
        d.chi_in = w[3];
        d.clo_in = w[0];
        return d;
    endfunction

    function automatic logic [PORT_W-1:0] mode_encode(input dir_t d);
        logic [PORT_W-1:0] w;
        w           = '0;
        w[MODE_BIT] = 1'b1;
        w[4]        = d.a_in;
        w[3]        = d.chi_in;
        w[1]        = d.b_in;
        w[0]        = d.clo_in;
        return w;
    endfunction

    // Drive enable (1 = output) for port p of a group
    function automatic logic [PORT_W-1:0] port_oe(input dir_t d, input int p);
        logic [PORT_W-1:0] oe;
        case (p)
            0:       oe = {PORT_W{~d.a_in}};
            1:       oe = {PORT_W{~d.b_in}};
            default: oe = {{NIB_W{~d.chi_in}}, {NIB_W{~d.clo_in}}};
        endcase
        return oe;
    endfunction

    function automatic sel_t decode_addr(input logic [ADDR_W-1:0] a);
        sel_t s;
        s.hit_grp = (int'(a) < NUM_GRP * GRP_SPAN);
        s.grp     = a[IDX_W +: GRP_W];
        s.idx     = a[IDX_W-1:0];
        s.irq_arm = (a == IRQ_ARM_OFS);
        s.irq_clr = (a == IRQ_CLR_OFS);
        return s;
    endfunction
endpackage

// File: rtl/dio48_sampler.sv
module dio48_sampler #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/dio48_group.sv
module dio48_group
    import dio48_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     idx,
    input  logic [PORT_W-1:0]    wdata,
    input  logic [GRP_LINES-1:0] pin_s,
    output logic [GRP_LINES-1:0] out_lines,
    output logic [GRP_LINES-1:0] oe_lines,
    output logic [PORT_W-1:0]    rd_data
);
    logic [PORTS_PER_GRP-1:0][PORT_W-1:0] lat_q;
    logic [PORTS_PER_GRP-1:0][PORT_W-1:0] oe_p;
    dir_t dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            if (int'(idx) == CTL_IDX) begin
                if (wdata[MODE_BIT]) dir_q <= mode_decode(wdata);
            end else begin
                for (int p = 0; p < PORTS_PER_GRP; p++)
                    if (int'(idx) == p) lat_q[p] <= wdata;
            end
        end
    end

    generate
        for (genvar p = 0; p < PORTS_PER_GRP; p++) begin : g_port
            assign oe_p[p]                     = port_oe(dir_q, p);
            assign out_lines[p*PORT_W +: PORT_W] = lat_q[p];
            assign oe_lines[p*PORT_W +: PORT_W]  = oe_p[p];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (int'(idx) == CTL_IDX) begin
            rd_data = mode_encode(dir_q);
        end else begin
            for (int p = 0; p < PORTS_PER_GRP; p++)
                if (int'(idx) == p)
                    rd_data = (pin_s[p*PORT_W +: PORT_W] & ~oe_p[p]) | (lat_q[p] & oe_p[p]);
        end
    end

    logic ctl_wr;
    assign ctl_wr = wr_en && (int'(idx) == CTL_IDX);

    p_ignore_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !wdata[MODE_BIT]) |=> $stable(oe_lines));

    p_port_a_dir_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata[MODE_BIT]) |=> (oe_lines[PORT_W-1:0] == {PORT_W{!$past(wdata[4])}}));

    p_nibble_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata[MODE_BIT]) |=>
            (oe_lines[2*PORT_W +: NIB_W] == {NIB_W{!$past(wdata[0])}}) &&
            (oe_lines[2*PORT_W+NIB_W +: NIB_W] == {NIB_W{!$past(wdata[3])}}));

    p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> $stable(out_lines));
endmodule

// File: rtl/dio48_irq.sv
module dio48_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    input  logic            arm,
    input  logic            disarm,
    input  logic            clear,
    output logic            irq_req
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] rise;
    logic            en_q;

    assign rise = src & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
            en_q   <= 1'b0;
        end else begin
            prev_q <= src;
            if (disarm)   en_q <= 1'b0;
            else if (arm) en_q <= 1'b1;
            if (disarm || clear) pend_q <= '0;
            else if (en_q)       pend_q <= pend_q | rise;
        end
    end

    assign irq_req = en_q & (|pend_q);

    p_edge_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (en_q && !disarm && !clear && (|rise)) |=> irq_req);

    p_arm_r9: assert property (@(posedge clk) disable iff (rst)
        (arm && !disarm) |=> en_q);

    p_disarm_r9: assert property (@(posedge clk) disable iff (rst)
        disarm |=> !irq_req);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clear |=> !irq_req);

    p_no_capture_r11: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !irq_req);
endmodule

// File: rtl/dio48_ctrl.sv
module dio48_ctrl
    import dio48_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [PORT_W-1:0]    bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [PORT_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pins_in,
    output logic [NUM_LINES-1:0] pins_out,
    output logic [NUM_LINES-1:0] pins_oe,
    output logic                 irq_req
);
    sel_t sel;
    assign sel = decode_addr(bus_addr);

    logic [NUM_LINES-1:0] pins_s;
    dio48_sampler #(.W(NUM_LINES)) u_sample (
        .clk(clk), .rst(rst), .d(pins_in), .q(pins_s)
    );

    logic [NUM_GRP-1:0][PORT_W-1:0] grp_rd;
    logic [NUM_GRP-1:0]             irq_src;

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            logic gwr;
            assign gwr = bus_wr && sel.hit_grp && (int'(sel.grp) == g);
            dio48_group u_grp (
                .clk(clk), .rst(rst), .wr_en(gwr), .idx(sel.idx), .wdata(bus_wdata),
                .pin_s(pins_s[g*GRP_LINES +: GRP_LINES]),
                .out_lines(pins_out[g*GRP_LINES +: GRP_LINES]),
                .oe_lines(pins_oe[g*GRP_LINES +: GRP_LINES]),
                .rd_data(grp_rd[g])
            );
            assign irq_src[g] = pins_s[g*GRP_LINES + 2*PORT_W + IRQ_BIT];
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (sel.hit_grp) bus_rdata = grp_rd[sel.grp];
    end

    dio48_irq #(.NSRC(NUM_GRP)) u_irq (
        .clk(clk), .rst(rst), .src(irq_src),
        .arm(bus_wr && sel.irq_arm),
        .disarm(bus_rd && sel.irq_arm),
        .clear(bus_wr && sel.irq_clr),
        .irq_req(irq_req)
    );

    p_unmapped_write_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !sel.hit_grp) |=> ($stable(pins_out) && $stable(pins_oe)));
endmodule

// File: tb/tb_dio48_ctrl.sv
module tb_dio48_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_rdata;
    logic [47:0] pins_in, pins_out, pins_oe;
    logic        irq_req;

    dio48_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe), .irq_req(irq_req)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Model: latches per port, direction per group {a,b,chi,clo} with 1 = input
    logic [7:0] m_lat [6];
    logic [3:0] m_dir [2];

    function automatic logic [47:0] exp_oe();
        logic [47:0] v;
        for (int g = 0; g < 2; g++) begin
            v[g*24 +: 8]      = {8{~m_dir[g][3]}};
            v[g*24 + 8 +: 8]  = {8{~m_dir[g][2]}};
            v[g*24 + 20 +: 4] = {4{~m_dir[g][1]}};
            v[g*24 + 16 +: 4] = {4{~m_dir[g][0]}};
        end
        return v;
    endfunction

    function automatic logic [47:0] exp_out();
        logic [47:0] v;
        for (int p = 0; p < 6; p++) v[p*8 +: 8] = m_lat[p];
        return v;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        logic [47:0] oe;
        int g, i, p;
        if (a >= 4'd8) return 8'h00;
        g = int'(a[2]);
        i = int'(a[1:0]);
        if (i == 3)
            return {3'b100, m_dir[g][3], m_dir[g][1], 1'b0, m_dir[g][2], m_dir[g][0]};
        p  = g * 3 + i;
        oe = exp_oe();
        return (pins_in[p*8 +: 8] & ~oe[p*8 +: 8]) | (m_lat[p] & oe[p*8 +: 8]);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a < 4'd8) begin
            if (a[1:0] == 2'd3) begin
                if (d[7]) m_dir[a[2]] = {d[4], d[1], d[3], d[0]};
            end else begin
                m_lat[int'(a[2]) * 3 + int'(a[1:0])] = d;
            end
        end
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_pins(input string req);
        check(req, 64'(pins_out), 64'(exp_out()));
        check(req, 64'(pins_oe), 64'(exp_oe()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [3:0] a;
        void'($urandom(32'd1234));
        for (int p = 0; p < 6; p++) m_lat[p] = 8'h00;
        m_dir[0] = 4'h0; m_dir[1] = 4'h0;
        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0; pins_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        check("R2 oe", 64'(pins_oe), 64'hFFFF_FFFF_FFFF);
        check("R2 out", 64'(pins_out), 64'h0);
        check("R2 irq", 64'(irq_req), 64'h0);
        bus_read(4'd3, rd); check("R2 mode0", 64'(rd), 64'h80);
        bus_read(4'd7, rd); check("R2 mode1", 64'(rd), 64'h80);

        // R1 mapping: group 1 port A is lines 24..31
        bus_write(4'd4, 8'hA5);
        check("R1 A1 lines", 64'(pins_out[31:24]), 64'hA5);
        bus_write(4'd2, 8'h3C);
        check("R1 C0 lines", 64'(pins_out[23:16]), 64'h3C);
        check_pins("R1 map");

        // R4 nibbles: upper C0 input only
        bus_write(4'd3, 8'h88);
        check("R4 C0 oe", 64'(pins_oe[23:16]), 64'h0F);
        check_pins("R4");
        bus_write(4'd3, 8'h81);
        check("R4 C0 oe lo", 64'(pins_oe[23:16]), 64'hF0);

        // R3 / R6: port A input keeps latch, back to output drives it
        bus_write(4'd0, 8'h5A);
        bus_write(4'd3, 8'h90);
        check("R3 A0 in", 64'(pins_oe[7:0]), 64'h00);
        check("R6 latch kept", 64'(pins_out[7:0]), 64'h5A);
        bus_write(4'd0, 8'hC3);
        bus_write(4'd3, 8'h80);
        check("R6 redrive", 64'(pins_out[7:0]), 64'hC3);
        check("R6 redrive oe", 64'(pins_oe[7:0]), 64'hFF);

        // R5: bit 7 clear ignored
        bus_write(4'd7, 8'h1B);
        check_pins("R5 ignored");
        bus_read(4'd7, rd); check("R5 mode1", 64'(rd), 64'h80);

        // R7 readback mix
        bus_write(4'd3, 8'h82);
        pins_in[15:8] = 8'h77;
        bus_read(4'd1, rd); check("R7 B0 pins", 64'(rd), 64'(exp_rd(4'd1)));
        bus_read(4'd3, rd); check("R7 mode enc", 64'(rd), 64'h82);
        bus_read(4'd9, rd); check("R7 unmapped", 64'(rd), 64'h00);

        // Random phase, interrupts disarmed
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom_range(0, 3));
            if (op == 0) begin
                pins_in = {$urandom, $urandom};
                @(negedge clk);
            end else begin
                do a = 4'($urandom_range(0, 14)); while (a == 4'hB);
                if (op == 3 && a < 4'd8) a[1:0] = 2'd3;
                bus_write(a, 8'($urandom));
            end
            check_pins("R1 R3 R4 R5 R6 random");
            check("R11 irq low", 64'(irq_req), 64'h0);
            do a = 4'($urandom_range(0, 15)); while (a == 4'hB);
            bus_read(a, rd);
            check("R7 random read", 64'(rd), 64'(exp_rd(a)));
        end

        // Interrupts
        pins_in = '0;
        repeat (2) @(negedge clk);
        pins_in[19] = 1'b1;                 // edge while disarmed
        repeat (2) @(negedge clk);
        bus_write(4'hB, 8'h00);
        check("R11 no stale", 64'(irq_req), 64'h0);
        pins_in[19] = 1'b0;                 // falling edge
        repeat (2) @(negedge clk);
        check("R8 falling", 64'(irq_req), 64'h0);
        pins_in[18] = 1'b1;                 // other line
        repeat (2) @(negedge clk);
        check("R8 other bit", 64'(irq_req), 64'h0);
        pins_in[19] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 line19", 64'(irq_req), 64'h1);
        repeat (3) @(negedge clk);
        check("R10 level", 64'(irq_req), 64'h1);
        bus_write(4'hF, 8'h5A);
        check("R10 clear", 64'(irq_req), 64'h0);
        pins_in[43] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 line43", 64'(irq_req), 64'h1);
        bus_read(4'hB, rd);
        check("R9 disarm", 64'(irq_req), 64'h0);
        bus_write(4'hB, 8'hFF);
        check("R9 rearm no pend", 64'(irq_req), 64'h0);
        pins_in[43] = 1'b0;
        @(negedge clk);
        pins_in[43] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 armed edge", 64'(irq_req), 64'h1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule